// File: doc/BRIEF.md
# Reverse-Channel Byte Receiver with Run-Length Expansion

This block is the host-side receiver for the reverse direction of an ECP-style parallel link. The peripheral puts a byte on the data lines and pulls its clock strobe low. It also drives a tag line: high marks a data byte and low marks a command byte. The block registers the byte and the tag, then answers by raising its acknowledge output. When the peripheral lets the strobe go high again, the block lowers the acknowledge. A low acknowledge tells the peripheral that the host is ready for another byte. Every peripheral input passes through a two-flop synchronizer before any logic uses it.

Commands with the top bit clear carry a run count N in bits 6:0. The next data byte is then written N+1 times into a downstream FIFO. Commands with the top bit set are channel addresses, and the block drops them. Bytes leave through a valid/ready push port. While the sink holds ready low, the block keeps valid high and holds the data still. It releases the acknowledge for the next byte only when three conditions hold: every replica of the current byte has been accepted, ready is high, and the strobe has returned high. As a result, a full FIFO stops the block from asking for more bytes. Dropping the enable input aborts the transfer. On the next edge the acknowledge goes low, and any pending count, any replicas not yet pushed and any byte in flight are discarded.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, host_ack is 0 and push_valid is 0.
- R2: A byte received with periph_ack high and no pending run count is pushed exactly once, with its value unchanged.
- R3: A byte received with periph_ack low and bit 7 equal to 0 arms a run count N from bits 6:0. The next data byte is pushed N+1 times, so N=0 gives 1 copy and N=127 gives 128 copies.
- R4: A command byte with bit 7 equal to 1 is ignored. It pushes nothing and leaves any armed count unchanged.
- R5: A data byte uses up the armed count. A later data byte with no new command is pushed once.
- R6: host_ack rises only after the strobe has been seen low while enabled, and only while no push is pending.
- R7: While push_valid is 1 and push_ready is 0, push_valid stays 1 and push_data stays stable.
- R8: host_ack stays high while push_valid is 1, and it falls only after a cycle in which push_ready was 1.
- R9: When rx_enable is 0, host_ack and push_valid are 0 from the next cycle on. The armed count, any remaining replicas and any byte in flight are discarded.
- R10: While rx_enable is 0, a strobe from the peripheral raises no acknowledge and causes no push.
- R11: When two run-count commands arrive back to back, the later one sets the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | High while the port is in reverse transfer mode |
| periph_clk_n | input | 1 | Peripheral strobe, low when the byte is valid |
| periph_ack | input | 1 | Byte tag: 1 for data, 0 for command |
| periph_data | input | 8 | Byte from the peripheral |
| host_ack | output | 1 | Handshake reply; low means ready for a byte |
| push_valid | output | 1 | Push of a byte toward the FIFO |
| push_data | output | 8 | Byte being pushed |
| push_ready | input | 1 | FIFO can take a byte (low when full) |

## Verification
Two functions can fall in the same cycle here. The first is back-pressure on a replica push while the peripheral's strobe release is being synchronized. The second is an abort that arrives while a push is stalled. The bench sweeps every run count from 0 to 127 and throttles ready on alternate counts, so strobe release and stall overlap many times. It checks that exactly N+1 copies of the right value arrive and that the acknowledge does not drop while a push is pending. A separate case drops the enable in the middle of a throttled run. It then checks that outputs go quiet on the next cycle and that the next data byte arrives as a single copy.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic {
    LNK_IDLE = 1'b0,
    LNK_HOLD = 1'b1
  } lnk_state_e;

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] value;
  } rx_byte_t;
endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= {W{RST_VAL}};
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ecp_rev_link.sv
module ecp_rev_link
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              strobe_n_s,
  input  logic              tag_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              exp_busy,
  input  logic              sink_ready,
  output logic              host_ack,
  output logic              evt_valid,
  output logic              evt_cmd,
  output logic [DATA_W-1:0] evt_data
);
  lnk_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LNK_IDLE;
      evt_valid <= 1'b0;
      evt_cmd   <= 1'b0;
      evt_data  <= '0;
    end else if (!enable) begin
      state_q   <= LNK_IDLE;
      evt_valid <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      case (state_q)
        LNK_IDLE: begin
          if (!strobe_n_s) begin
            evt_valid <= 1'b1;
            evt_cmd   <= ~tag_s;
            evt_data  <= data_s;
            state_q   <= LNK_HOLD;
          end
        end
        LNK_HOLD: begin
          if (strobe_n_s && !exp_busy && sink_ready) begin
            state_q <= LNK_IDLE;
          end
        end
        default: state_q <= LNK_IDLE;
      endcase
    end
  end

  assign host_ack = (state_q == LNK_HOLD);
endmodule

// File: rtl/ecp_rev_rle.sv
module ecp_rev_rle #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              evt_valid,
  input  logic              evt_cmd,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              busy
);
  localparam int CNT_W = DATA_W - 1;
  localparam int REM_W = DATA_W;

  logic              armed_q;
  logic [CNT_W-1:0]  count_q;
  logic [REM_W-1:0]  remain_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      count_q  <= '0;
      remain_q <= '0;
      hold_q   <= '0;
    end else if (!enable) begin
      armed_q  <= 1'b0;
      count_q  <= '0;
      remain_q <= '0;
    end else if (evt_valid) begin
      if (evt_cmd) begin
        if (!evt_data[DATA_W-1]) begin
          armed_q <= 1'b1;
          count_q <= evt_data[CNT_W-1:0];
        end
      end else begin
        hold_q   <= evt_data;
        remain_q <= armed_q ? ({1'b0, count_q} + REM_W'(1)) : REM_W'(1);
        armed_q  <= 1'b0;
      end
    end else if ((remain_q != '0) && push_ready) begin
      remain_q <= remain_q - REM_W'(1);
    end
  end

  assign push_valid = (remain_q != '0);
  assign push_data  = hold_q;
  assign busy       = push_valid || evt_valid;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              periph_clk_n,
  input  logic              periph_ack,
  input  logic [DATA_W-1:0] periph_data,
  output logic              host_ack,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  input  logic              push_ready
);
  localparam int BUS_W = DATA_W + 1;

  logic              strobe_n_s;
  logic [BUS_W-1:0]  bus_s;
  logic              evt_valid;
  logic              evt_cmd;
  logic [DATA_W-1:0] evt_data;
  logic              exp_busy;

  ecp_rev_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(periph_clk_n), .q(strobe_n_s)
  );

  ecp_rev_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({periph_ack, periph_data}), .q(bus_s)
  );

  ecp_rev_link #(.DATA_W(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable),
    .strobe_n_s(strobe_n_s), .tag_s(bus_s[BUS_W-1]), .data_s(bus_s[DATA_W-1:0]),
    .exp_busy(exp_busy), .sink_ready(push_ready),
    .host_ack(host_ack), .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_data(evt_data)
  );

  ecp_rev_rle #(.DATA_W(DATA_W)) u_rle (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable),
    .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_data(evt_data),
    .push_ready(push_ready), .push_valid(push_valid), .push_data(push_data),
    .busy(exp_busy)
  );
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              host_ack,
  input logic              push_valid,
  input logic [DATA_W-1:0] push_data,
  input logic              push_ready
);
  a_r9_abort_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!host_ack && !push_valid));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

  a_r8_ack_covers_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> host_ack);

  a_r8_release_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_ack) && $past(rx_enable)) |-> $past(push_ready));

  a_r6_rise_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> (!push_valid && $past(rx_enable)));
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .host_ack(host_ack),
  .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready)
);

// File: tb/tb_ecp_rev_rx.sv
module tb_ecp_rev_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_enable = 1'b0;
  logic       periph_clk_n = 1'b1;
  logic       periph_ack = 1'b1;
  logic [7:0] periph_data = 8'h00;
  logic       host_ack;
  logic       push_valid;
  logic [7:0] push_data;
  logic       push_ready = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;
  int bp_cnt = 0;
  int rx_n = 0;
  logic [7:0] rx_buf [0:1023];

  always #10 clk = ~clk;

  ecp_rev_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .periph_clk_n(periph_clk_n), .periph_ack(periph_ack), .periph_data(periph_data),
    .host_ack(host_ack), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready)
  );

  // sink: pick ready for the coming edge, then log the transfer it completes
  always @(negedge clk) begin
    bp_cnt = bp_cnt + 1;
    push_ready = bp_on ? ((bp_cnt % 4) != 3) : 1'b1;
    if (push_valid && push_ready && rst_n) begin
      rx_buf[rx_n % 1024] = push_data;
      rx_n = rx_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit is_cmd, input logic [7:0] b);
    @(negedge clk);
    while (host_ack) @(negedge clk);
    periph_ack = ~is_cmd;
    periph_data = b;
    periph_clk_n = 1'b0;
    @(negedge clk);
    while (!host_ack) @(negedge clk);
    periph_clk_n = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk);
    while (host_ack || push_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_run(input string req, input int base, input int exp_n, input logic [7:0] v);
    int got;
    bit same;
    got = rx_n - base;
    same = 1'b1;
    for (int i = base; i < rx_n; i++) if (rx_buf[i % 1024] !== v) same = 1'b0;
    check(got == exp_n, req, got, exp_n);
    check(same, {req, " value"}, same, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(host_ack == 1'b0, "R1 host_ack", host_ack, 0);
    check(push_valid == 1'b0, "R1 push_valid", push_valid, 0);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    repeat (3) @(negedge clk);

    // R2 plain data bytes
    base = rx_n;
    send(1'b0, 8'hA7);
    drain();
    check_run("R2 single", base, 1, 8'hA7);
    base = rx_n;
    send(1'b0, 8'h00);
    drain();
    check_run("R2 zero byte", base, 1, 8'h00);

    // R3 sweep of all run counts, back-pressure on odd counts
    for (int n = 0; n < 128; n++) begin
      bp_on = n[0];
      base = rx_n;
      send(1'b1, 8'(n));
      send(1'b0, 8'(n) ^ 8'h5A);
      drain();
      check_run("R3 run", base, n + 1, 8'(n) ^ 8'h5A);
    end
    bp_on = 1'b0;

    // R5 count consumed by one data byte
    base = rx_n;
    send(1'b0, 8'h3C);
    drain();
    check_run("R5 consumed", base, 1, 8'h3C);

    // R4 channel address ignored, alone and with a count armed
    base = rx_n;
    send(1'b1, 8'h85);
    drain();
    check(rx_n == base, "R4 no push", rx_n - base, 0);
    send(1'b0, 8'h11);
    drain();
    check_run("R4 alone", base, 1, 8'h11);
    base = rx_n;
    send(1'b1, 8'h03);
    send(1'b1, 8'hFF);
    send(1'b0, 8'h22);
    drain();
    check_run("R4 keeps count", base, 4, 8'h22);

    // R11 later count wins
    base = rx_n;
    send(1'b1, 8'h05);
    send(1'b1, 8'h02);
    send(1'b0, 8'h99);
    drain();
    check_run("R11 last count", base, 3, 8'h99);

    // R9 abort in the middle of a throttled run
    bp_on = 1'b1;
    base = rx_n;
    send(1'b1, 8'd100);
    send(1'b0, 8'hE1);
    while (rx_n - base < 10) @(negedge clk);
    rx_enable = 1'b0;
    @(negedge clk);
    check(host_ack == 1'b0, "R9 host_ack", host_ack, 0);
    check(push_valid == 1'b0, "R9 push_valid", push_valid, 0);
    check((rx_n - base) < 101, "R9 truncated", rx_n - base, 100);
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    rx_enable = 1'b1;
    base = rx_n;
    send(1'b0, 8'h44);
    drain();
    check_run("R9 count discarded", base, 1, 8'h44);

    // R10 strobes ignored while disabled
    rx_enable = 1'b0;
    base = rx_n;
    periph_ack = 1'b1;
    periph_data = 8'h77;
    periph_clk_n = 1'b0;
    begin
      bit saw = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (host_ack || push_valid) saw = 1'b1;
      end
      check(!saw, "R10 no ack", saw, 0);
    end
    periph_clk_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_n == base, "R10 no push", rx_n - base, 0);

    // R6 handshake order observed at the port
    periph_ack = 1'b1;
    periph_data = 8'h5E;
    repeat (2) @(negedge clk);
    check(host_ack == 1'b0, "R6 idle low", host_ack, 0);
    periph_clk_n = 1'b0;
    @(negedge clk);
    check(host_ack == 1'b0, "R6 not early", host_ack, 0);
    repeat (4) @(negedge clk);
    check(host_ack == 1'b1, "R6 acked", host_ack, 1);
    repeat (4) @(negedge clk);
    check(host_ack == 1'b1, "R8 held while strobe low", host_ack, 1);
    periph_clk_n = 1'b1;
    drain();
    check(host_ack == 1'b0, "R6 released", host_ack, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule